// File: doc/BRIEF.md
# Registered Three-Port Word Exchanger

This block moves words between one host-side port (A) and two memory-side ports (1B and 2B). It is meant for interleaved memory with even and odd banks. Four transfer registers hold the words. Two carry words outward from A, one towards each B port. Two carry words inward, one from each B port, back to A. Each transfer register has its own active-low load strobe. A control register samples the A drive strobe, the shared B drive strobe and the return-path select on every rising edge. Because of this, a change of direction or of return path always takes effect on a clock edge.

Each bidirectional port is split into three signals: a data-in bus, a data-out bus and a drive flag. A per-port "external valid" input tells the block when another agent is driving the wire. When nobody drives a port, its wire value is the last level that was on it, which models a bus keeper. The value the registers capture from a port is the resolved wire level. That level is the block's own output while the block drives the port. Otherwise it is data-in while external valid is high. In all other cases it is the kept level.

Top module: `tpx_bus_exchanger`

## Requirements
- R1: A synchronous active-high reset clears all four transfer registers and all three keeper levels to zero. It sets both registered drive strobes to inactive (high) and the return select to 0. After reset, all drive flags are 0 and every data-out bus reads zero.
- R2: The A-to-1B register loads the resolved A wire level on a rising edge only when its load strobe is low at that edge. 1B data-out always shows this register.
- R3: The A-to-2B register loads the resolved A wire level on a rising edge only when its load strobe is low at that edge. 2B data-out always shows this register.
- R4: The 1B-to-A register loads the resolved 1B wire level on a rising edge only when its load strobe is low at that edge.
- R5: The 2B-to-A register loads the resolved 2B wire level on a rising edge only when its load strobe is low at that edge.
- R6: The return select is sampled on each rising edge. After an edge that sampled it high, A data-out shows the 1B-to-A register. After an edge that sampled it low, A data-out shows the 2B-to-A register.
- R7: The A drive strobe (active low) is sampled on each rising edge. The A drive flag equals the inverse of the sampled value, starting at the edge that sampled it.
- R8: One active-low B drive strobe is sampled on each rising edge. Both the 1B and 2B drive flags equal its inverse, starting at that edge.
- R9: A port that is driven neither by the block nor externally keeps its last driven level. That level is either the block's own last output or the last externally valid data-in. A register that loads from such a port captures the kept level, and data-in is ignored.
- R10: While the block drives a port, a register that loads from that port captures the block's own output on that port, and data-in is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous active-high reset |
| a_din | input | 12 | A port incoming wire data |
| a_ext_vld | input | 1 | A port driven by another agent |
| a_dout | output | 12 | A port outgoing data (selected return register) |
| a_drv | output | 1 | Block drives the A port |
| b1_din | input | 12 | 1B port incoming wire data |
| b1_ext_vld | input | 1 | 1B port driven by another agent |
| b1_dout | output | 12 | 1B port outgoing data (A-to-1B register) |
| b1_drv | output | 1 | Block drives the 1B port |
| b2_din | input | 12 | 2B port incoming wire data |
| b2_ext_vld | input | 1 | 2B port driven by another agent |
| b2_dout | output | 12 | 2B port outgoing data (A-to-2B register) |
| b2_drv | output | 1 | Block drives the 2B port |
| ld_a2b1_n | input | 1 | Load strobe of the A-to-1B register, active low |
| ld_a2b2_n | input | 1 | Load strobe of the A-to-2B register, active low |
| ld_b12a_n | input | 1 | Load strobe of the 1B-to-A register, active low |
| ld_b22a_n | input | 1 | Load strobe of the 2B-to-A register, active low |
| a_oe_n | input | 1 | A drive strobe, active low, registered |
| b_oe_n | input | 1 | Shared B drive strobe, active low, registered |
| ret_sel | input | 1 | Return-path select, registered: 1 = from 1B, 0 = from 2B |

## Verification
Every output comes straight from a register, so a wrong internal state shows at the ports one edge after it arises, or one edge after the select next points at it. A wrongly loaded outward register shows on its B data-out at the very next sample. A wrongly loaded inward register shows on A data-out as soon as the select chooses that path. A bad keeper level stays hidden until a register loads from the undriven port. It then appears one edge later on that register's data-out. A mis-registered strobe or select shows one edge early or late on the drive flags, or as the wrong source on A data-out.

// File: rtl/tpx_pkg.sv
package tpx_pkg;

    parameter int unsigned WORD_W = 12;

    // Transfer register indices
    localparam int unsigned NUM_XFER = 4;
    localparam int unsigned XR_A1B = 0;
    localparam int unsigned XR_A2B = 1;
    localparam int unsigned XR_B1A = 2;
    localparam int unsigned XR_B2A = 3;

    // Port indices
    localparam int unsigned NUM_PORT = 3;
    localparam int unsigned PT_A  = 0;
    localparam int unsigned PT_B1 = 1;
    localparam int unsigned PT_B2 = 2;

    typedef struct packed {
        logic a_oe_n;
        logic b_oe_n;
        logic sel;
    } tpx_ctl_t;

    localparam tpx_ctl_t CTL_RESET = '{a_oe_n: 1'b1, b_oe_n: 1'b1, sel: 1'b0};

    // Which port feeds a given transfer register
    function automatic int unsigned xfer_src(input int unsigned idx);
        case (idx)
            XR_A1B, XR_A2B: return PT_A;
            XR_B1A:         return PT_B1;
            default:        return PT_B2;
        endcase
    endfunction

endpackage

// File: rtl/tpx_xfer_reg.sv
module tpx_xfer_reg #(
    parameter int unsigned W = tpx_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (!ld_n) q <= d;
    end

    AST_XREG_LOAD: assert property (@(posedge clk) disable iff (rst)
        !ld_n |=> (q == $past(d)));               // R2 R3 R4 R5
    AST_XREG_KEEP: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> $stable(q));                      // R2 R3 R4 R5
endmodule

// File: rtl/tpx_ctl_reg.sv
module tpx_ctl_reg
    import tpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     a_oe_n,
    input  logic     b_oe_n,
    input  logic     sel,
    output tpx_ctl_t ctl_q
);
    tpx_ctl_t ctl_d;

    always_comb begin
        ctl_d.a_oe_n = a_oe_n;
        ctl_d.b_oe_n = b_oe_n;
        ctl_d.sel    = sel;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RESET;
        else     ctl_q <= ctl_d;
    end
endmodule

// File: rtl/tpx_port_cell.sv
module tpx_port_cell #(
    parameter int unsigned W = tpx_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         drv,
    input  logic [W-1:0] out_w,
    input  logic [W-1:0] in_w,
    input  logic         ext_vld,
    output logic [W-1:0] wire_w
);
    logic [W-1:0] keep_q;

    // Resolved wire level: own drive, else external drive, else keeper
    always_comb begin
        if (drv)          wire_w = out_w;
        else if (ext_vld) wire_w = in_w;
        else              wire_w = keep_q;
    end

    always_ff @(posedge clk) begin
        if (rst) keep_q <= '0;
        else     keep_q <= wire_w;
    end

    AST_KEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!drv && !ext_vld) |=> $stable(keep_q));   // R9
endmodule

// File: rtl/tpx_bus_exchanger.sv
module tpx_bus_exchanger
    import tpx_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_din,
    input  logic         a_ext_vld,
    output logic [W-1:0] a_dout,
    output logic         a_drv,
    input  logic [W-1:0] b1_din,
    input  logic         b1_ext_vld,
    output logic [W-1:0] b1_dout,
    output logic         b1_drv,
    input  logic [W-1:0] b2_din,
    input  logic         b2_ext_vld,
    output logic [W-1:0] b2_dout,
    output logic         b2_drv,
    input  logic         ld_a2b1_n,
    input  logic         ld_a2b2_n,
    input  logic         ld_b12a_n,
    input  logic         ld_b22a_n,
    input  logic         a_oe_n,
    input  logic         b_oe_n,
    input  logic         ret_sel
);
    tpx_ctl_t     ctl_q;
    logic [W-1:0] xr_q   [NUM_XFER];
    logic         xr_ldn [NUM_XFER];
    logic [W-1:0] pt_out [NUM_PORT];
    logic [W-1:0] pt_in  [NUM_PORT];
    logic         pt_vld [NUM_PORT];
    logic         pt_drv [NUM_PORT];
    logic [W-1:0] pt_wire[NUM_PORT];

    tpx_ctl_reg u_ctl (
        .clk    (clk),
        .rst    (rst),
        .a_oe_n (a_oe_n),
        .b_oe_n (b_oe_n),
        .sel    (ret_sel),
        .ctl_q  (ctl_q)
    );

    always_comb begin
        xr_ldn[XR_A1B] = ld_a2b1_n;
        xr_ldn[XR_A2B] = ld_a2b2_n;
        xr_ldn[XR_B1A] = ld_b12a_n;
        xr_ldn[XR_B2A] = ld_b22a_n;

        pt_in[PT_A]   = a_din;
        pt_in[PT_B1]  = b1_din;
        pt_in[PT_B2]  = b2_din;
        pt_vld[PT_A]  = a_ext_vld;
        pt_vld[PT_B1] = b1_ext_vld;
        pt_vld[PT_B2] = b2_ext_vld;

        pt_drv[PT_A]  = !ctl_q.a_oe_n;
        pt_drv[PT_B1] = !ctl_q.b_oe_n;
        pt_drv[PT_B2] = !ctl_q.b_oe_n;

        pt_out[PT_A]  = ctl_q.sel ? xr_q[XR_B1A] : xr_q[XR_B2A];
        pt_out[PT_B1] = xr_q[XR_A1B];
        pt_out[PT_B2] = xr_q[XR_A2B];
    end

    for (genvar gi = 0; gi < NUM_XFER; gi++) begin : g_xfer
        localparam int unsigned SRC = xfer_src(gi);
        tpx_xfer_reg #(.W(W)) u_reg (
            .clk  (clk),
            .rst  (rst),
            .ld_n (xr_ldn[gi]),
            .d    (pt_wire[SRC]),
            .q    (xr_q[gi])
        );
    end

    for (genvar gp = 0; gp < NUM_PORT; gp++) begin : g_port
        tpx_port_cell #(.W(W)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .drv     (pt_drv[gp]),
            .out_w   (pt_out[gp]),
            .in_w    (pt_in[gp]),
            .ext_vld (pt_vld[gp]),
            .wire_w  (pt_wire[gp])
        );
    end

    assign a_dout  = pt_out[PT_A];
    assign b1_dout = pt_out[PT_B1];
    assign b2_dout = pt_out[PT_B2];
    assign a_drv   = pt_drv[PT_A];
    assign b1_drv  = pt_drv[PT_B1];
    assign b2_drv  = pt_drv[PT_B2];

    AST_A_DRV_LAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (a_drv == !$past(a_oe_n)));                          // R7
    AST_B_DRV_LAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (b1_drv == !$past(b_oe_n) && b2_drv == !$past(b_oe_n))); // R8
    AST_RET_PICK: assert property (@(posedge clk) disable iff (rst)
        ($past(ret_sel) && $stable(xr_q[XR_B1A])) |-> (a_dout == xr_q[XR_B1A])); // R6
endmodule

// File: tb/tpx_bus_exchanger_tb_top.sv
module tpx_bus_exchanger_tb_top;
    localparam int W = 12;
    localparam int MAX_CYC = 5000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_din = '0, b1_din = '0, b2_din = '0;
    logic         a_ext_vld = 0, b1_ext_vld = 0, b2_ext_vld = 0;
    logic         ld_a2b1_n = 1, ld_a2b2_n = 1, ld_b12a_n = 1, ld_b22a_n = 1;
    logic         a_oe_n = 1, b_oe_n = 1, ret_sel = 0;
    logic [W-1:0] a_dout, b1_dout, b2_dout;
    logic         a_drv, b1_drv, b2_drv;

    always #4 clk = ~clk;   // 125 MHz

    tpx_bus_exchanger #(.W(W)) dut_i (
        .clk(clk), .rst(rst),
        .a_din(a_din), .a_ext_vld(a_ext_vld), .a_dout(a_dout), .a_drv(a_drv),
        .b1_din(b1_din), .b1_ext_vld(b1_ext_vld), .b1_dout(b1_dout), .b1_drv(b1_drv),
        .b2_din(b2_din), .b2_ext_vld(b2_ext_vld), .b2_dout(b2_dout), .b2_drv(b2_drv),
        .ld_a2b1_n(ld_a2b1_n), .ld_a2b2_n(ld_a2b2_n),
        .ld_b12a_n(ld_b12a_n), .ld_b22a_n(ld_b22a_n),
        .a_oe_n(a_oe_n), .b_oe_n(b_oe_n), .ret_sel(ret_sel)
    );

    // Behavioural reference state
    logic [W-1:0] m_a1b = '0, m_a2b = '0, m_b1a = '0, m_b2a = '0;
    logic [W-1:0] m_ka = '0, m_k1 = '0, m_k2 = '0;
    logic         m_aoe = 1, m_boe = 1, m_sel = 0;
    int           n_vec = 0, n_bad = 0, cyc = 0;
    bit           done = 0;
    string        phase = "R1";

    always @(posedge clk) begin
        logic [W-1:0] ao, wa, w1, w2;
        ao = m_sel ? m_b1a : m_b2a;
        wa = !m_aoe ? ao    : (a_ext_vld  ? a_din  : m_ka);
        w1 = !m_boe ? m_a1b : (b1_ext_vld ? b1_din : m_k1);
        w2 = !m_boe ? m_a2b : (b2_ext_vld ? b2_din : m_k2);
        if (rst) begin
            m_a1b = '0; m_a2b = '0; m_b1a = '0; m_b2a = '0;
            m_ka = '0; m_k1 = '0; m_k2 = '0;
            m_aoe = 1; m_boe = 1; m_sel = 0;
        end else begin
            if (!ld_a2b1_n) m_a1b = wa;
            if (!ld_a2b2_n) m_a2b = wa;
            if (!ld_b12a_n) m_b1a = w1;
            if (!ld_b22a_n) m_b2a = w2;
            m_ka = wa; m_k1 = w1; m_k2 = w2;
            m_aoe = a_oe_n; m_boe = b_oe_n; m_sel = ret_sel;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] cycle %0d: actual %0h expected %0h", tag, phase, cyc, act, exp);
        end
    endtask

    // Compare away from the active edge; all outputs are registered
    always @(negedge clk) if (!done) begin
        logic [W-1:0] ea;
        ea = m_sel ? m_b1a : m_b2a;
        cyc++;
        chk(a_drv  == !m_aoe, "R7 a_drv",  a_drv,  !m_aoe);
        chk(b1_drv == !m_boe, "R8 b1_drv", b1_drv, !m_boe);
        chk(b2_drv == !m_boe, "R8 b2_drv", b2_drv, !m_boe);
        chk(b1_dout == m_a1b, "R2 b1_dout", b1_dout, m_a1b);
        chk(b2_dout == m_a2b, "R3 b2_dout", b2_dout, m_a2b);
        chk(a_dout == ea, m_sel ? "R4 R6 a_dout" : "R5 R6 a_dout", a_dout, ea);
    end

    task automatic idle_ctl();
        ld_a2b1_n = 1; ld_a2b2_n = 1; ld_b12a_n = 1; ld_b22a_n = 1;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        tick(3);
        rst = 0;
        // R2 R3: outward loads gated by their own strobes
        phase = "R2R3";
        a_ext_vld = 1; a_din = 12'hA5C;
        ld_a2b1_n = 0; tick(1); idle_ctl();
        a_din = 12'h3B7; tick(1);
        ld_a2b2_n = 0; tick(1); idle_ctl();
        a_din = 12'hFFF; tick(2);
        // R4 R5 R6: inward loads and return select
        phase = "R4R5R6";
        b1_ext_vld = 1; b2_ext_vld = 1; b1_din = 12'h111; b2_din = 12'h222;
        ld_b12a_n = 0; tick(1); idle_ctl();
        b1_din = 12'h999; ret_sel = 1; tick(1);
        ld_b22a_n = 0; tick(1); idle_ctl(); ret_sel = 0; tick(1);
        ret_sel = 1; tick(1); ret_sel = 0; tick(1);
        // R7 R8: drive strobes take effect one edge later
        phase = "R7R8";
        a_oe_n = 0; tick(1); b_oe_n = 0; tick(1); a_oe_n = 1; tick(1); b_oe_n = 1; tick(1);
        // R9: keeper holds last external level, then last own level
        phase = "R9";
        b1_din = 12'h5A5; tick(1);
        b1_ext_vld = 0; b1_din = 12'h0F0; tick(2);
        ld_b12a_n = 0; tick(1); idle_ctl(); ret_sel = 1; tick(1);
        a_ext_vld = 0; a_oe_n = 0; tick(2);
        a_oe_n = 1; a_din = 12'h777; tick(2);
        ld_a2b1_n = 0; tick(1); idle_ctl(); tick(1);
        // R10: block-driven port loops its own output back
        phase = "R10";
        b_oe_n = 0; b2_ext_vld = 1; b2_din = 12'hDEF; tick(1);
        ld_b22a_n = 0; tick(1); idle_ctl(); ret_sel = 0; b_oe_n = 1; tick(2);
        // Mixed random traffic
        phase = "mix";
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            a_din = r[11:0]; b1_din = $urandom; b2_din = $urandom;
            a_ext_vld = r[12]; b1_ext_vld = r[13]; b2_ext_vld = r[14];
            ld_a2b1_n = r[15] | r[16]; ld_a2b2_n = r[17] | r[18];
            ld_b12a_n = r[19] | r[20]; ld_b22a_n = r[21] | r[22];
            a_oe_n = r[23]; b_oe_n = r[24]; ret_sel = r[25];
            rst = (r[31:26] == 6'd0);
            tick(1);
        end
        rst = 0; tick(1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int w;
        for (w = 0; w < MAX_CYC; w++) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", w);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule